// File: doc/BRIEF.md
# Coordinate-Addressed Pixel Port for an 8-bit Processor Bus

This block lets a small microprocessor reach a frame buffer through six byte-wide registers instead of a flat memory window. The processor drives an asynchronous bus with a chip select that is active high, a write strobe that is active low, three address lines and eight data lines. The strobes, address and data are sampled into the system clock domain, so the processor's bus timing need not relate to the block's clock. The processor loads a column pointer (nine bits, split across two registers), a row, and a scroll offset. It then reads or writes a pixel byte through the pixel data register. Each pixel access turns into one memory request to a shared memory arbiter. The arbiter answers with a one-cycle acknowledge.

The row is taken relative to the scroll offset, so row 0 always names the top visible line. The linear byte address is ((row + offset) mod 256) * 400 + column. When automatic advance is on, every pixel read or write steps the column by one. Reads come from a holding latch. The block fills that latch ahead of time whenever the pointer changes, after each pixel write, and after each pixel read, so the processor never waits on memory. A control register holds the advance enable, the high-resolution mode select, and an interrupt enable. The same register shows the live vertical-blank level. The interrupt line is active low and falls when the raster enters vertical blank.

Top module: `pixbus_slave`

## Requirements
- R1: After reset, every register reads 0, `irq_n` is 1, `mem_req` is 0, `hires_mode` is 0 and `scroll_rows` is 0.
- R2: The register addresses are: 0 = column bits [7:0]; 1 = column bit 8 in data bit 0 (bits 7:1 read 0); 2 = row; 3 = pixel data; 4 = control; 5 = scroll offset. Addresses 6 and 7 read 0, and writes to them have no effect. Registers 0, 1, 2 and 5 read back the value written.
- R3: A write takes effect only on a rising edge of `bus_we_n` while `bus_cs` is 1. A pulse on `bus_we_n` while `bus_cs` is 0 changes nothing.
- R4: A write of the pixel data register issues exactly one memory write with `mem_we`=1, the written byte on `mem_wdata`, and `mem_addr` = ((row + offset) mod 256) * 400 + column. Both row and offset are 8-bit.
- R5: `mem_req` stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay stable, until the cycle in which `mem_ack` is 1. `mem_req` is low in the cycle after an acknowledge.
- R6: With control bit 0 set, each pixel read or write advances the 9-bit column by one. The column wraps from 511 to 0 and the row is unchanged.
- R7: With control bit 0 clear, pixel reads and writes leave the column and the row unchanged.
- R8: A pixel read returns the latched byte at the current pointer. The latch is refilled after any change to the column, row or offset, and after every pixel access. Consecutive reads with advance on therefore return consecutive bytes, and a read after a write at the same place returns the written byte.
- R9: With control bit 2 set, `irq_n` goes to 0 on a rising edge of `vblank_in`. It stays at 0 until any write to the control register or until bit 2 is cleared. With bit 2 clear, `irq_n` stays 1.
- R10: Control bits [2:0] read back as written. Bit 3 reads the current `vblank_in` level and ignores writes. Bits 7:4 read 0. `hires_mode` follows bit 1, and `scroll_rows` follows register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs | input | 1 | Processor chip select, active high, asynchronous |
| bus_we_n | input | 1 | Processor write strobe, active low, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor (combinational on `bus_addr`) |
| vblank_in | input | 1 | Raster is in vertical blank (system clock domain) |
| irq_n | output | 1 | Vertical-blank interrupt, active low |
| hires_mode | output | 1 | High-resolution mode select for the video side |
| scroll_rows | output | 8 | Scroll offset for the video side |
| mem_req | output | 1 | Memory request to the arbiter |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge from the arbiter |

## Verification
The bench targets the column wrap from 511 to 0 under automatic advance. A design with a carry into the row, or a column that stops at 511, would put the next pixel on the wrong line. It checks the row-plus-offset sum where the total passes 255. A design that widens the sum would address past the scroll window instead of wrapping to the top. It checks that releasing chip select after a pixel write is not also taken as a read. A design that confused the two would advance the column twice. It also checks that an interrupt already raised survives the end of vertical blank and clears only on a control write or when disabled. A design that tracked the blank level would drop the interrupt before the handler ran.

// File: rtl/pixbus_pkg.sv
// Package: shared widths, register addresses and bus sample type for the
// coordinate-addressed pixel port. Assumes an 8-bit data, 3-bit address bus.
package pixbus_pkg;
    localparam int BUS_AW = 3;
    localparam int BUS_DW = 8;

    typedef enum logic [BUS_AW-1:0] {
        RA_COL_LO  = 3'd0,
        RA_COL_HI  = 3'd1,
        RA_ROW     = 3'd2,
        RA_PIXEL   = 3'd3,
        RA_CTRL    = 3'd4,
        RA_SCROLL  = 3'd5
    } reg_addr_e;

    // One sample of the asynchronous processor bus
    typedef struct packed {
        logic              cs;
        logic              we_n;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_smp_t;

    // Control bit positions
    localparam int CB_ADVANCE = 0;
    localparam int CB_HIRES   = 1;
    localparam int CB_IRQEN   = 2;
    localparam int CB_VBLANK  = 3;
endpackage

// File: rtl/pixbus_sync.sv
// Module: pixbus_sync
// Brings the asynchronous processor bus into the clock domain through a chain
// of SYNC_STAGES sample registers, then reports a write event (a rising edge
// of the write strobe under chip select) and a read event (chip select
// dropping with no write seen while it was high). Assumes address and data
// stay valid for a few clocks around the strobe edges.
module pixbus_sync
    import pixbus_pkg::*;
#(
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              wr_evt,
    output logic              rd_evt,
    output logic [BUS_AW-1:0] ev_addr,
    output logic [BUS_DW-1:0] ev_data
);
    localparam int LAST = SYNC_STAGES - 1;

    bus_smp_t chain [SYNC_STAGES];
    logic     wrote_q;
    bus_smp_t newer, older;

    // First stage samples the raw bus
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '{cs: 1'b0, we_n: 1'b1, addr: '0, data: '0};
        else        chain[0] <= '{cs: bus_cs, we_n: bus_we_n, addr: bus_addr, data: bus_wdata};
    end

    // Remaining stages shift the sample along
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '{cs: 1'b0, we_n: 1'b1, addr: '0, data: '0};
            else        chain[g] <= chain[g-1];
        end
    end

    assign newer = chain[LAST-1];
    assign older = chain[LAST];

    // Remember that this chip-select window carried a write
    always_ff @(posedge clk) begin
        if (!rst_n)         wrote_q <= 1'b0;
        else if (!older.cs) wrote_q <= 1'b0;
        else if (!older.we_n) wrote_q <= 1'b1;
    end

    assign wr_evt  = older.cs && !older.we_n && newer.we_n;
    assign rd_evt  = older.cs && !newer.cs && older.we_n && !wrote_q;
    assign ev_addr = older.addr;
    assign ev_data = older.data;
endmodule

// File: rtl/pixbus_regs.sv
// Module: pixbus_regs
// Holds the column, row, scroll and control registers, steps the column on
// pixel accesses, forms the linear memory address, raises memory write and
// prefetch triggers, drives the read mux and the vertical-blank interrupt.
// Assumes at most one bus event per cycle and vblank_in in the clock domain.
module pixbus_regs
    import pixbus_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int ROW_W     = 8,
    parameter int ROW_BYTES = 400,
    parameter int MEM_AW    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [BUS_AW-1:0] ev_addr,
    input  logic [BUS_DW-1:0] ev_data,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [BUS_DW-1:0] pix_hold,
    input  logic              vblank_in,
    output logic              irq_n,
    output logic              hires_mode,
    output logic [ROW_W-1:0]  scroll_rows,
    output logic [MEM_AW-1:0] cur_addr,
    output logic              wr_set,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [BUS_DW-1:0] wr_data,
    output logic              pf_set
);
    localparam int HI_W = COL_W - BUS_DW;

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q, scr_q;
    logic [2:0]       ctrl_q;
    logic             vb_q, irq_q;
    logic             px_evt, ctrl_wr, vb_rise, ptr_wr;
    logic [ROW_W-1:0] eff_row;

    assign px_evt  = (wr_evt || rd_evt) && (ev_addr == RA_PIXEL);
    assign ctrl_wr = wr_evt && (ev_addr == RA_CTRL);
    assign ptr_wr  = wr_evt && (ev_addr == RA_COL_LO || ev_addr == RA_COL_HI ||
                                ev_addr == RA_ROW    || ev_addr == RA_SCROLL);
    assign vb_rise = vblank_in && !vb_q;

    // Register writes and column advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            scr_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_evt) begin
            case (ev_addr)
                RA_COL_LO: col_q[BUS_DW-1:0]     <= ev_data;
                RA_COL_HI: col_q[COL_W-1:BUS_DW] <= ev_data[HI_W-1:0];
                RA_ROW:    row_q                 <= ev_data[ROW_W-1:0];
                RA_SCROLL: scr_q                 <= ev_data[ROW_W-1:0];
                RA_CTRL:   ctrl_q                <= ev_data[2:0];
                RA_PIXEL:  if (ctrl_q[CB_ADVANCE]) col_q <= col_q + COL_W'(1);
                default:   ;
            endcase
        end else if (px_evt && ctrl_q[CB_ADVANCE]) begin
            col_q <= col_q + COL_W'(1);
        end
    end

    // Linear address: wrapped effective row times row pitch plus column
    assign eff_row  = row_q + scr_q;
    assign cur_addr = MEM_AW'(eff_row) * MEM_AW'(ROW_BYTES) + MEM_AW'(col_q);

    // Triggers towards the memory sequencer (one cycle after the event)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_set  <= 1'b0;
            pf_set  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_set <= wr_evt && (ev_addr == RA_PIXEL);
            pf_set <= px_evt || ptr_wr;
            if (wr_evt && ev_addr == RA_PIXEL) begin
                wr_addr <= cur_addr;
                wr_data <= ev_data;
            end
        end
    end

    // Vertical-blank edge memory and interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            vb_q <= vblank_in;
            if (ctrl_wr || !ctrl_q[CB_IRQEN]) irq_q <= 1'b0;
            else if (vb_rise)                 irq_q <= 1'b1;
        end
    end

    assign irq_n       = !irq_q;
    assign hires_mode  = ctrl_q[CB_HIRES];
    assign scroll_rows = scr_q;

    // Read mux on the live bus address
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_COL_LO: bus_rdata = col_q[BUS_DW-1:0];
            RA_COL_HI: bus_rdata = BUS_DW'(col_q[COL_W-1:BUS_DW]);
            RA_ROW:    bus_rdata = BUS_DW'(row_q);
            RA_PIXEL:  bus_rdata = pix_hold;
            RA_CTRL:   bus_rdata = {4'b0000, vblank_in, ctrl_q};
            RA_SCROLL: bus_rdata = BUS_DW'(scr_q);
            default:   bus_rdata = '0;
        endcase
    end

    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (px_evt && ctrl_q[CB_ADVANCE]) |=> (col_q == $past(col_q) + COL_W'(1)) && $stable(row_q)); // R6
    AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (px_evt && !ctrl_q[CB_ADVANCE]) |=> ($stable(col_q) && $stable(row_q))); // R7
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> irq_n); // R9
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_rise && ctrl_q[CB_IRQEN] && !ctrl_wr) |=> !irq_n); // R9
endmodule

// File: rtl/pixbus_memreq.sv
// Module: pixbus_memreq
// Queues one pending write and one pending prefetch, issues them one at a
// time to the arbiter (write first) and holds each request until the
// acknowledge. Read data lands in the pixel holding latch. Assumes the
// arbiter acknowledges for exactly one cycle and only while requested.
module pixbus_memreq
    import pixbus_pkg::*;
#(
    parameter int MEM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic              pf_set,
    input  logic [MEM_AW-1:0] cur_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [BUS_DW-1:0] mem_wdata,
    input  logic [BUS_DW-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [BUS_DW-1:0] pix_hold
);
    logic              wr_pend, pf_pend, busy;
    logic [MEM_AW-1:0] wq_addr;
    logic [BUS_DW-1:0] wq_data;
    logic              issue_wr, issue_pf;

    assign issue_wr = !busy && wr_pend;
    assign issue_pf = !busy && !wr_pend && pf_pend;

    // Pending flags and queued write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
            pf_pend <= 1'b0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            wr_pend <= wr_set || (wr_pend && !issue_wr);
            pf_pend <= pf_set || (pf_pend && !issue_pf);
            if (wr_set) begin
                wq_addr <= wr_addr;
                wq_data <= wr_data;
            end
        end
    end

    // Request issue, hold until acknowledge, read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            pix_hold  <= '0;
        end else if (busy) begin
            if (mem_ack) begin
                busy    <= 1'b0;
                mem_req <= 1'b0;
                if (!mem_we) pix_hold <= mem_rdata;
            end
        end else if (issue_wr) begin
            busy      <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= wq_addr;
            mem_wdata <= wq_data;
        end else if (issue_pf) begin
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_addr;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req); // R5
endmodule

// File: rtl/pixbus_slave.sv
// Module: pixbus_slave (top)
// Coordinate-addressed pixel port: processor bus synchroniser, register
// block and memory request sequencer. Assumes the processor holds address
// and data for a few clocks around its strobe edges.
module pixbus_slave
    import pixbus_pkg::*;
#(
    parameter int COL_W       = 9,
    parameter int ROW_W       = 8,
    parameter int ROW_BYTES   = 400,
    parameter int MEM_AW      = 17,
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we_n,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              vblank_in,
    output logic              irq_n,
    output logic              hires_mode,
    output logic [ROW_W-1:0]  scroll_rows,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);
    logic              wr_evt, rd_evt;
    logic [BUS_AW-1:0] ev_addr;
    logic [BUS_DW-1:0] ev_data;
    logic [BUS_DW-1:0] pix_hold;
    logic [MEM_AW-1:0] cur_addr, wr_addr;
    logic [BUS_DW-1:0] wr_data;
    logic              wr_set, pf_set;

    pixbus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_evt(wr_evt), .rd_evt(rd_evt), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    pixbus_regs #(.COL_W(COL_W), .ROW_W(ROW_W), .ROW_BYTES(ROW_BYTES), .MEM_AW(MEM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_evt(wr_evt), .rd_evt(rd_evt), .ev_addr(ev_addr), .ev_data(ev_data),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pix_hold(pix_hold),
        .vblank_in(vblank_in), .irq_n(irq_n), .hires_mode(hires_mode),
        .scroll_rows(scroll_rows), .cur_addr(cur_addr),
        .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data), .pf_set(pf_set)
    );

    pixbus_memreq #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data),
        .pf_set(pf_set), .cur_addr(cur_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pix_hold(pix_hold)
    );
endmodule

// File: tb/sim_pixbus_slave.sv
// Bench for pixbus_slave: a vector table of register write/readback pairs,
// then directed tests for reset, memory addressing, advance, prefetch and
// the interrupt. A behavioural memory answers requests after two cycles.
module sim_pixbus_slave;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_we_n = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        vblank_in = 1'b0;
    logic        irq_n, hires_mode;
    logic [7:0]  scroll_rows;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = '0;

    int n_tests = 0, n_fail = 0;
    int wr_cnt = 0, viol = 0;
    logic [16:0] last_wa = '0;
    logic [7:0]  last_wd = '0;
    logic [7:0]  mem [int];
    logic [7:0]  rd;
    bit          done = 0;

    pixbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vblank_in(vblank_in), .irq_n(irq_n), .hires_mode(hires_mode),
        .scroll_rows(scroll_rows), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory responder and handshake monitor (R5)
    initial begin
        int cnt = 0;
        logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
        logic [16:0] p_addr = '0;
        forever begin
            @(negedge clk);
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we)) viol++;
            if (p_ack && mem_req) viol++;
            mem_ack = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[int'(mem_addr)] = mem_wdata;
                        wr_cnt++;
                        last_wa = mem_addr;
                        last_wd = mem_wdata;
                    end else begin
                        mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
                    end
                end
            end else cnt = 0;
            p_req = mem_req; p_addr = mem_addr; p_we = mem_we; p_ack = mem_ack;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs = 1'b1; bus_we_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_cs = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_cs = 1'b1; bus_we_n = 1'b1;
        repeat (2) @(negedge clk);
        d = bus_rdata;
        bus_cs = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // {addr, write data, expected readback}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 8'hA5, 8'hA5}, {3'd1, 8'hFF, 8'h01}, {3'd2, 8'h3C, 8'h3C},
        {3'd5, 8'h07, 8'h07}, {3'd4, 8'hF2, 8'h02}, {3'd6, 8'h55, 8'h00},
        {3'd7, 8'hAA, 8'h00}, {3'd4, 8'h00, 8'h00}
    };

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 hires", hires_mode, 0);
        chk("R1 scroll", scroll_rows, 0);
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            chk("R1 reg zero", rd, 0);
        end

        // R2 R10 register table
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][18:16], VEC[i][15:8]);
            bus_read(VEC[i][18:16], rd);
            chk("R2 readback", rd, {24'h0, VEC[i][7:0]});
        end

        // R3 strobe without chip select is ignored
        bus_write(3'd2, 8'h11);
        @(negedge clk); bus_addr = 3'd2; bus_wdata = 8'h99; bus_we_n = 1'b0;
        repeat (3) @(negedge clk); bus_we_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(3'd2, rd);
        chk("R3 no cs", rd, 8'h11);

        // R4 address forming, R7 pointer holds
        bus_write(3'd0, 8'h23); bus_write(3'd1, 8'h01);
        bus_write(3'd2, 8'd5);  bus_write(3'd5, 8'd3);
        chk("R10 scroll out", scroll_rows, 3);
        begin
            int w0 = wr_cnt;
            bus_write(3'd3, 8'h5A);
            chk("R4 one write", wr_cnt - w0, 1);
        end
        chk("R4 addr", last_wa, 17'd3491);
        chk("R4 data", last_wd, 8'h5A);
        bus_read(3'd0, rd); chk("R7 col lo", rd, 8'h23);
        bus_read(3'd1, rd); chk("R7 col hi", rd, 8'h01);
        bus_read(3'd2, rd); chk("R7 row", rd, 8'd5);
        // R8 read after write returns written byte, pointer still held
        bus_read(3'd3, rd); chk("R8 read after write", rd, 8'h5A);
        bus_read(3'd0, rd); chk("R7 col after read", rd, 8'h23);

        // R4 row+offset wraps at 256
        bus_write(3'd2, 8'd250); bus_write(3'd5, 8'd10);
        bus_write(3'd3, 8'hC3);
        chk("R4 wrap addr", last_wa, 17'd1891);

        // R6 advance, column wraps 511 -> 0
        bus_write(3'd4, 8'h01);
        bus_write(3'd0, 8'hFF); bus_write(3'd1, 8'h01);
        bus_write(3'd3, 8'h44);
        chk("R6 write at 511", last_wa, 17'd2111);
        bus_read(3'd0, rd); chk("R6 col lo wrap", rd, 8'h00);
        bus_read(3'd1, rd); chk("R6 col hi wrap", rd, 8'h00);
        bus_read(3'd2, rd); chk("R6 row kept", rd, 8'd250);

        // R8 consecutive prefetched reads with advance
        mem[810] = 8'h11; mem[811] = 8'h22; mem[812] = 8'h33;
        bus_write(3'd5, 8'd0); bus_write(3'd2, 8'd2); bus_write(3'd0, 8'd10);
        bus_read(3'd3, rd); chk("R8 read 0", rd, 8'h11);
        bus_read(3'd3, rd); chk("R8 read 1", rd, 8'h22);
        bus_read(3'd3, rd); chk("R8 read 2", rd, 8'h33);
        bus_read(3'd0, rd); chk("R6 col after reads", rd, 8'd13);

        // R9 R10 interrupt and status
        bus_write(3'd4, 8'h0E);
        chk("R10 hires out", hires_mode, 1);
        @(negedge clk); vblank_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 irq low", irq_n, 0);
        bus_read(3'd4, rd); chk("R10 vblank bit", rd, 8'h0E);
        @(negedge clk); vblank_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 irq held", irq_n, 0);
        bus_read(3'd4, rd); chk("R10 vblank clear", rd, 8'h06);
        bus_write(3'd4, 8'h06);
        chk("R9 cleared by ctrl write", irq_n, 1);
        @(negedge clk); vblank_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 irq again", irq_n, 0);
        bus_write(3'd4, 8'h02);
        chk("R9 cleared by disable", irq_n, 1);
        @(negedge clk); vblank_in = 1'b0;
        repeat (2) @(negedge clk); vblank_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 masked", irq_n, 1);

        chk("R5 handshake violations", viol, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule